// File: doc/BRIEF.md
# Radio Transceiver Mode Sequencer

This block sequences a narrowband half-duplex radio module. It owns the module's supply enable and the two active-low lines that select the transmit or receive path. It takes host requests to tune, receive or transmit over a valid/ready handshake. To tune, it calls an external synthesizer-programming block. It then holds off data for a settle time that depends on the path taken. It checks the lock-detect input part way through that settle. At the start of every transmission it runs a preamble pattern generator. On a small set of restricted channels it caps how long the transmitter may stay on and then imposes a pause.

Every delay is counted in milliseconds from a prescaled tick derived from the clock-rate parameter. Requests use a two-bit code: 0 = no-op, 1 = go to receive, 2 = go to transmit, 3 = tune to `req_chan`. A request is taken on a clock edge where `req_valid` and `req_ready` are both high.

The controller has nine states: OFF, IDLE, TUNE, SETTLE, RX, TXSW, PRE, TX and RXSW. The transitions are:

- OFF goes to IDLE after one cycle.
- IDLE goes to TUNE on a tune request.
- TUNE goes to SETTLE on `pll_done`.
- SETTLE goes to RX when the settle time expires.
- RX goes to TUNE on a tune request. It goes to TXSW on a transmit request when no pause is running.
- TXSW goes to PRE after the switch time.
- PRE goes to TX after the preamble time.
- TX goes to TUNE on a tune request and to RXSW on a receive request.
- TXSW, PRE and TX each go to RXSW when the duty pause begins.
- RXSW goes to RX after the switch time.

Top module: `radio_mode_seq`

## Requirements
- R1: For the first cycle after reset `pwr_en` is 0 and both select lines are high. From the next cycle `pwr_en` is 1, with both selects still high and `data_ok` low, until a tune request is taken.
- R2: `rxsel_n` is low in TUNE, SETTLE, RX and RXSW. `txsel_n` is low in TXSW, PRE and TX. Both selects are never low together.
- R3: In IDLE, receive, transmit and no-op requests are taken but change no output. A receive request in RX and a transmit request in TX also have no effect.
- R4: A tune request raises `pll_req`, with `pll_chan` equal to the requested channel, and holds it until `pll_done`. A tune request taken in TX drops `txsel_n` high and `rxsel_n` low in the very next cycle.
- R5: `data_ok` rises FIRST_MS ms after the `pll_done` cycle for the first tune since reset, and CHANGE_MS ms after it for every later tune.
- R6: LOCK_MS ms after `pll_done`, `lock_fail` is set if the filtered lock is not asserted. It is cleared by the next tune request.
- R7: Lock detect passes through two synchronizing flops. It counts as locked only after LOCK_RUN consecutive high samples, so a toggling input never locks.
- R8: A transmit request in RX, or a receive request in TX, holds `data_ok` low for SWITCH_MS ms with the new select already low.
- R9: After the TX switch time, `pre_active` is high for PREAMBLE_MS ms before `data_ok`. `pre_bit` starts at 1 and steps every BIT_CLKS cycles. The pattern is 1,0 repeating when `pre_fast`=0, and 1,1,0,0 repeating when `pre_fast`=1. Outside the preamble `pre_bit` is 0.
- R10: On channels RESTRICT_LO..RESTRICT_HI, after TX_LIMIT_MS ms of continuous transmit select, `duty_hold` rises for PAUSE_MS ms and the sequencer returns to receive. Transmit requests during the pause are ignored. Other channels transmit without limit.
- R11: `req_ready` is high only in IDLE, RX and TX, and in TX only while `duty_hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_op | input | 2 | Request code (0 no-op, 1 rx, 2 tx, 3 tune) |
| req_chan | input | CH_W | Channel number for a tune request |
| req_ready | output | 1 | Request accepted on this edge when valid |
| pwr_en | output | 1 | Radio supply enable |
| txsel_n | output | 1 | Transmit path select, active low |
| rxsel_n | output | 1 | Receive path select, active low |
| pll_req | output | 1 | Synthesizer programming request |
| pll_chan | output | CH_W | Channel to program |
| pll_done | input | 1 | Programming finished (one-cycle pulse) |
| lock_det | input | 1 | Asynchronous lock detect, high = locked |
| lock_fail | output | 1 | Lock was absent at the check point |
| data_ok | output | 1 | Settle complete, data may pass |
| duty_hold | output | 1 | Mandatory transmit pause in progress |
| pre_fast | input | 1 | Selects the 1100 preamble pattern |
| pre_bit | output | 1 | Preamble bit |
| pre_active | output | 1 | Preamble in progress |

## Verification
With P clocks per millisecond, every result is due at a fixed cycle offset:
- state and selects follow the accepting edge by one cycle;
- SETTLE lasts exactly FIRST_MS·P or CHANGE_MS·P cycles from the cycle after `pll_done`, and `lock_fail` updates at LOCK_MS·P cycles into it;
- the switch and preamble states last SWITCH_MS·P and PREAMBLE_MS·P cycles;
- `duty_hold` rises after TX_LIMIT_MS·P transmit-select cycles, and the forced RXSW follows one cycle later.

A behavioural model in the bench advances integer cycle counters on each rising edge and compares every output at the falling edge. Each expectation is therefore tested in exactly the cycle it is due, never a cycle early or late.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;
    typedef enum logic [3:0] {
        ST_OFF, ST_IDLE, ST_TUNE, ST_SETTLE, ST_RX,
        ST_TXSW, ST_PRE, ST_TX, ST_RXSW
    } seq_state_t;

    localparam logic [1:0] OP_NOP  = 2'd0;
    localparam logic [1:0] OP_RX   = 2'd1;
    localparam logic [1:0] OP_TX   = 2'd2;
    localparam logic [1:0] OP_CHAN = 2'd3;
endpackage

// File: rtl/seq_ms_timer.sv
module seq_ms_timer #(
    parameter int PER  = 200000,
    parameter int MS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    output logic            tick,
    output logic [MS_W-1:0] ms
);
    localparam int CW = (PER > 1) ? $clog2(PER) : 1;

    logic [CW-1:0] div_q;

    assign tick = (div_q == CW'(PER - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            ms    <= '0;
        end else if (clr) begin
            div_q <= '0;
            ms    <= '0;
        end else if (tick) begin
            div_q <= '0;
            ms    <= ms + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/seq_lock_filter.sv
module seq_lock_filter #(
    parameter int LOCK_RUN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_det,
    output logic locked
);
    localparam int RW = $clog2(LOCK_RUN + 1);

    logic          sync1_q, sync2_q;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            run_q   <= '0;
        end else begin
            sync1_q <= lock_det;
            sync2_q <= sync1_q;
            if (!sync2_q)
                run_q <= '0;
            else if (run_q != RW'(LOCK_RUN))
                run_q <= run_q + 1'b1;
        end
    end

    assign locked = (run_q == RW'(LOCK_RUN));

    // R7: acceptance only follows a high synchronized sample
    assert_lock_seen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> $past(sync2_q));
endmodule

// File: rtl/seq_duty_guard.sv
module seq_duty_guard #(
    parameter int CLK_PER_MS  = 200000,
    parameter int TX_LIMIT_MS = 40000,
    parameter int PAUSE_MS    = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic hold
);
    localparam int MAXV = (TX_LIMIT_MS > PAUSE_MS) ? TX_LIMIT_MS : PAUSE_MS;
    localparam int MS_W = $clog2(MAXV + 1);

    logic            tick;
    logic [MS_W-1:0] ms;
    logic            hit, release_now, clr;

    assign hit         = !hold && active && tick && (ms == MS_W'(TX_LIMIT_MS - 1));
    assign release_now = hold && tick && (ms == MS_W'(PAUSE_MS - 1));
    assign clr         = hit || release_now || (!hold && !active);

    seq_ms_timer #(.PER(CLK_PER_MS), .MS_W(MS_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .ms(ms)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           hold <= 1'b0;
        else if (hit)         hold <= 1'b1;
        else if (release_now) hold <= 1'b0;
    end

    // R10: a pause only starts out of a transmitting cycle
    assert_hold_from_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(active));
endmodule

// File: rtl/seq_preamble_gen.sv
module seq_preamble_gen #(
    parameter int BIT_CLKS = 41667
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic fast,
    output logic bit_out
);
    localparam int DW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

    logic [DW-1:0] div_q;
    logic [1:0]    ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            ph_q  <= '0;
        end else if (!en) begin
            div_q <= '0;
            ph_q  <= '0;
        end else if (div_q == DW'(BIT_CLKS - 1)) begin
            div_q <= '0;
            ph_q  <= ph_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign bit_out = en && (fast ? !ph_q[1] : !ph_q[0]);

    // R9: every preamble opens on a one
    assert_pre_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> bit_out);
endmodule

// File: rtl/radio_mode_seq.sv
module radio_mode_seq
    import radio_seq_pkg::*;
#(
    parameter int CLK_HZ      = 200_000_000,
    parameter int CH_W        = 6,
    parameter int FIRST_MS    = 40,
    parameter int CHANGE_MS   = 20,
    parameter int LOCK_MS     = 20,
    parameter int SWITCH_MS   = 5,
    parameter int PREAMBLE_MS = 20,
    parameter int TX_LIMIT_MS = 40000,
    parameter int PAUSE_MS    = 2000,
    parameter int RESTRICT_LO = 1,
    parameter int RESTRICT_HI = 3,
    parameter int LOCK_RUN    = 8,
    parameter int BIT_CLKS    = 41667
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [1:0]      req_op,
    input  logic [CH_W-1:0] req_chan,
    output logic            req_ready,
    output logic            pwr_en,
    output logic            txsel_n,
    output logic            rxsel_n,
    output logic            pll_req,
    output logic [CH_W-1:0] pll_chan,
    input  logic            pll_done,
    input  logic            lock_det,
    output logic            lock_fail,
    output logic            data_ok,
    output logic            duty_hold,
    input  logic            pre_fast,
    output logic            pre_bit,
    output logic            pre_active
);
    localparam int CLK_PER_MS = CLK_HZ / 1000;
    localparam int M1   = (FIRST_MS > CHANGE_MS) ? FIRST_MS : CHANGE_MS;
    localparam int M2   = (M1 > PREAMBLE_MS) ? M1 : PREAMBLE_MS;
    localparam int M3   = (M2 > SWITCH_MS) ? M2 : SWITCH_MS;
    localparam int MS_W = $clog2(M3 + 1);

    seq_state_t      state_q, state_d;
    logic [CH_W-1:0] chan_q;
    logic            chan_set_q;
    logic            lock_fail_q;
    logic            tick;
    logic [MS_W-1:0] ms;
    logic            locked;
    logic            req_accept, tune_req;
    logic            settle_hit, lock_hit, sw_hit, pre_hit;
    logic            restricted, tx_on;

    assign req_accept = req_valid && req_ready;
    assign tune_req   = req_accept && (req_op == OP_CHAN);

    seq_ms_timer #(.PER(CLK_PER_MS), .MS_W(MS_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .clr(state_d != state_q), .tick(tick), .ms(ms)
    );

    seq_lock_filter #(.LOCK_RUN(LOCK_RUN)) u_lock (
        .clk(clk), .rst_n(rst_n), .lock_det(lock_det), .locked(locked)
    );

    assign restricted = (chan_q >= CH_W'(RESTRICT_LO)) && (chan_q <= CH_W'(RESTRICT_HI));

    seq_duty_guard #(.CLK_PER_MS(CLK_PER_MS), .TX_LIMIT_MS(TX_LIMIT_MS),
                     .PAUSE_MS(PAUSE_MS)) u_duty (
        .clk(clk), .rst_n(rst_n), .active(tx_on && restricted), .hold(duty_hold)
    );

    seq_preamble_gen #(.BIT_CLKS(BIT_CLKS)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(pre_active), .fast(pre_fast), .bit_out(pre_bit)
    );

    assign settle_hit = tick && (ms == (chan_set_q ? MS_W'(CHANGE_MS - 1)
                                                   : MS_W'(FIRST_MS - 1)));
    assign lock_hit   = tick && (ms == MS_W'(LOCK_MS - 1));
    assign sw_hit     = tick && (ms == MS_W'(SWITCH_MS - 1));
    assign pre_hit    = tick && (ms == MS_W'(PREAMBLE_MS - 1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    state_d = ST_IDLE;
            ST_IDLE:   if (tune_req) state_d = ST_TUNE;
            ST_TUNE:   if (pll_done) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_hit) state_d = ST_RX;
            ST_RX: begin
                if (tune_req)
                    state_d = ST_TUNE;
                else if (req_accept && req_op == OP_TX && !duty_hold)
                    state_d = ST_TXSW;
            end
            ST_TXSW: begin
                if (duty_hold)   state_d = ST_RXSW;
                else if (sw_hit) state_d = ST_PRE;
            end
            ST_PRE: begin
                if (duty_hold)    state_d = ST_RXSW;
                else if (pre_hit) state_d = ST_TX;
            end
            ST_TX: begin
                if (duty_hold)
                    state_d = ST_RXSW;
                else if (tune_req)
                    state_d = ST_TUNE;
                else if (req_accept && req_op == OP_RX)
                    state_d = ST_RXSW;
            end
            ST_RXSW:   if (sw_hit) state_d = ST_RX;
            default:   state_d = ST_OFF;
        endcase
    end

    // state and bookkeeping registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_OFF;
            chan_q      <= '0;
            chan_set_q  <= 1'b0;
            lock_fail_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (tune_req)
                chan_q <= req_chan;
            if (state_q == ST_SETTLE && settle_hit)
                chan_set_q <= 1'b1;
            if (tune_req)
                lock_fail_q <= 1'b0;
            else if (state_q == ST_SETTLE && lock_hit)
                lock_fail_q <= !locked;
        end
    end

    // outputs decoded from state
    always_comb begin
        pwr_en     = 1'b1;
        txsel_n    = 1'b1;
        rxsel_n    = 1'b1;
        pll_req    = 1'b0;
        data_ok    = 1'b0;
        req_ready  = 1'b0;
        pre_active = 1'b0;
        tx_on      = 1'b0;
        unique case (state_q)
            ST_OFF:    pwr_en = 1'b0;
            ST_IDLE:   req_ready = 1'b1;
            ST_TUNE:   begin rxsel_n = 1'b0; pll_req = 1'b1; end
            ST_SETTLE: rxsel_n = 1'b0;
            ST_RX:     begin rxsel_n = 1'b0; data_ok = 1'b1; req_ready = 1'b1; end
            ST_TXSW:   begin txsel_n = 1'b0; tx_on = 1'b1; end
            ST_PRE:    begin txsel_n = 1'b0; tx_on = 1'b1; pre_active = 1'b1; end
            ST_TX: begin
                txsel_n   = 1'b0;
                tx_on     = 1'b1;
                data_ok   = 1'b1;
                req_ready = !duty_hold;
            end
            ST_RXSW:   rxsel_n = 1'b0;
            default:   pwr_en = 1'b0;
        endcase
    end

    assign pll_chan  = chan_q;
    assign lock_fail = lock_fail_q;

    // R2: both paths never selected together
    assert_sel_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!txsel_n && !rxsel_n));
    // R1: no path selected while the module is unpowered
    assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> (txsel_n && rxsel_n));
    // R4: retuning happens only in receive
    assert_tune_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pll_req |-> (!rxsel_n && txsel_n));
    // R6: a new tune clears the lock flag
    assert_fail_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tune_req |=> !lock_fail);
    // R5: data_ok opens only out of a settle, switch or preamble state
    assert_ready_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ok) |-> ($past(state_q) == ST_SETTLE || $past(state_q) == ST_RXSW
                            || $past(state_q) == ST_PRE));
    // R10: the pause takes the transmitter off on the next cycle
    assert_hold_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(duty_hold) |=> txsel_n);
endmodule

// File: tb/radio_mode_seq_tb.sv
`timescale 1ns/1ps
module radio_mode_seq_tb;
    localparam int P        = 8;
    localparam int CLK_HZ   = P * 1000;
    localparam int FIRST    = 6;
    localparam int CHANGE   = 3;
    localparam int LOCKMS   = 3;
    localparam int SW       = 2;
    localparam int PRE      = 4;
    localparam int LIMIT    = 10;
    localparam int PAUSE    = 4;
    localparam int BITC     = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [5:0] req_chan = 6'd0;
    logic req_ready, pwr_en, txsel_n, rxsel_n, pll_req, lock_fail, data_ok;
    logic duty_hold, pre_bit, pre_active;
    logic [5:0] pll_chan;
    logic pll_done = 1'b0;
    logic lock_det = 1'b1;
    logic pre_fast = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit glitch = 0;
    bit lock_good = 1;

    always #2.5 clk = ~clk;

    radio_mode_seq #(
        .CLK_HZ(CLK_HZ), .CH_W(6), .FIRST_MS(FIRST), .CHANGE_MS(CHANGE),
        .LOCK_MS(LOCKMS), .SWITCH_MS(SW), .PREAMBLE_MS(PRE), .TX_LIMIT_MS(LIMIT),
        .PAUSE_MS(PAUSE), .RESTRICT_LO(1), .RESTRICT_HI(3), .LOCK_RUN(4), .BIT_CLKS(BITC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_chan(req_chan), .req_ready(req_ready), .pwr_en(pwr_en),
        .txsel_n(txsel_n), .rxsel_n(rxsel_n), .pll_req(pll_req), .pll_chan(pll_chan),
        .pll_done(pll_done), .lock_det(lock_det), .lock_fail(lock_fail),
        .data_ok(data_ok), .duty_hold(duty_hold), .pre_fast(pre_fast),
        .pre_bit(pre_bit), .pre_active(pre_active)
    );

    // ---------------- behavioural reference model ----------------
    localparam int M_OFF = 0, M_IDLE = 1, M_TUNE = 2, M_SETTLE = 3, M_RX = 4,
                   M_TXSW = 5, M_PRE = 6, M_TX = 7, M_RXSW = 8;
    int m_st = M_OFF;
    int m_t = 0;
    int m_chan = 0;
    bit m_chanset = 0;
    bit m_fail = 0;
    bit m_hold = 0;
    int m_run = 0;
    int m_pause = 0;

    function automatic bit m_ready();
        return (m_st == M_IDLE) || (m_st == M_RX) || (m_st == M_TX && !m_hold);
    endfunction

    function automatic bit m_txon();
        return (m_st == M_TXSW) || (m_st == M_PRE) || (m_st == M_TX);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = M_OFF; m_t = 0; m_chan = 0; m_chanset = 0; m_fail = 0;
            m_hold = 0; m_run = 0; m_pause = 0;
        end else begin
            bit acc, hold_now;
            int nst;
            acc = req_valid && m_ready();
            hold_now = m_hold;
            // duty pause bookkeeping
            if (!m_hold) begin
                if (m_txon() && m_chan >= 1 && m_chan <= 3) begin
                    m_run++;
                    if (m_run == LIMIT * P) begin m_hold = 1; m_run = 0; m_pause = 0; end
                end else m_run = 0;
            end else begin
                m_pause++;
                if (m_pause == PAUSE * P) begin m_hold = 0; m_pause = 0; end
            end
            nst = m_st;
            m_t++;
            case (m_st)
                M_OFF:  nst = M_IDLE;
                M_IDLE: if (acc && req_op == 2'd3) nst = M_TUNE;
                M_TUNE: if (pll_done) nst = M_SETTLE;
                M_SETTLE: begin
                    if (m_t == LOCKMS * P) m_fail = !lock_good;
                    if (m_t == (m_chanset ? CHANGE : FIRST) * P) begin
                        nst = M_RX; m_chanset = 1;
                    end
                end
                M_RX: begin
                    if (acc && req_op == 2'd3) nst = M_TUNE;
                    else if (acc && req_op == 2'd2 && !hold_now) nst = M_TXSW;
                end
                M_TXSW: if (hold_now) nst = M_RXSW; else if (m_t == SW * P) nst = M_PRE;
                M_PRE:  if (hold_now) nst = M_RXSW; else if (m_t == PRE * P) nst = M_TX;
                M_TX: begin
                    if (hold_now) nst = M_RXSW;
                    else if (acc && req_op == 2'd3) nst = M_TUNE;
                    else if (acc && req_op == 2'd1) nst = M_RXSW;
                end
                M_RXSW: if (m_t == SW * P) nst = M_RX;
                default: nst = M_OFF;
            endcase
            if (acc && req_op == 2'd3) begin m_chan = req_chan; m_fail = 0; end
            if (nst != m_st) m_t = 0;
            m_st = nst;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int idx, eb;
            idx = m_t / BITC;
            eb = (m_st == M_PRE) ? (pre_fast ? ((idx % 4) < 2) : ((idx % 2) == 0)) : 0;
            chk("R1", "pwr_en", pwr_en, m_st != M_OFF);
            chk("R2/R3", "rxsel_n", rxsel_n,
                !(m_st == M_TUNE || m_st == M_SETTLE || m_st == M_RX || m_st == M_RXSW));
            chk("R2/R3", "txsel_n", txsel_n, !m_txon());
            chk("R4", "pll_req", pll_req, m_st == M_TUNE);
            if (m_st == M_TUNE) chk("R4", "pll_chan", pll_chan, m_chan);
            chk("R5/R8", "data_ok", data_ok, m_st == M_RX || m_st == M_TX);
            chk("R6/R7", "lock_fail", lock_fail, m_fail);
            chk("R3/R11", "req_ready", req_ready, m_ready());
            chk("R9", "pre_active", pre_active, m_st == M_PRE);
            chk("R9", "pre_bit", pre_bit, eb);
            chk("R10", "duty_hold", duty_hold, m_hold);
        end
    end

    // synthesizer programming block stand-in
    int pll_cnt = 0;
    always @(negedge clk) begin
        if (pll_req && !pll_done) begin
            pll_cnt++;
            if (pll_cnt == 5) begin pll_done <= 1'b1; pll_cnt = 0; end
        end else pll_done <= 1'b0;
        if (glitch) lock_det <= ~lock_det;
    end

    task automatic send(input logic [1:0] op, input int ch);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_chan = 6'(ch);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ok();
        while (!data_ok) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;                       // R1: power-up ordering
        wait_cyc(4);
        send(2'd2, 0);                      // R3: tx ignored in IDLE
        send(2'd1, 0);                      // R3: rx ignored in IDLE
        send(2'd0, 0);
        wait_cyc(5);
        send(2'd3, 10);                     // R5: first tune, long settle
        wait_ok();
        send(2'd1, 0);                      // R3: rx in RX has no effect
        wait_cyc(4);
        send(2'd2, 0);                      // R8/R9: switch then 1010 preamble
        wait_ok();
        wait_cyc(10);
        send(2'd2, 0);                      // R3: tx in TX has no effect
        lock_good = 0; glitch = 1;          // R7: toggling lock never accepted
        send(2'd3, 20);                     // R4: retune from TX forces RX; R6 fail
        wait_ok();
        glitch = 0; lock_det = 1'b1;
        wait_cyc(20);
        lock_good = 1;
        pre_fast = 1'b1;
        send(2'd2, 0);                      // R9: 1100 preamble
        wait_ok();
        send(2'd1, 0);                      // R8: back to RX
        wait_ok();
        wait_cyc(3);
        send(2'd3, 2);                      // R6 clear; restricted channel
        wait_ok();
        send(2'd2, 0);                      // R10: run into the duty limit
        wait_cyc(20);
        while (!duty_hold) @(negedge clk);
        wait_cyc(1);
        wait_ok();
        send(2'd2, 0);                      // R10: tx during pause ignored
        wait_cyc(PAUSE * P + 5);
        send(2'd2, 0);                      // R10: allowed again after pause
        wait_ok();
        send(2'd1, 0);
        wait_ok();
        send(2'd3, 46);                     // R10: unrestricted channel
        wait_ok();
        pre_fast = 1'b0;
        send(2'd2, 0);
        wait_cyc(LIMIT * P + 60);
        send(2'd1, 0);
        wait_ok();
        wait_cyc(5);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog R1-sequence: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule